// File: doc/BRIEF.md
# Capture-to-Coprocessor Frame Sequencer

This block sits on the programmable-logic side of a link to an external signal processor and paces image frames in both directions. It waits in an idle state for a capture command. It then accepts already-preprocessed pixels into an outbound buffer. Each time that buffer climbs to half its depth, it asks the processor to fetch data by direct memory access. Once a whole frame has been taken in, it waits for an interrupt from the processor saying that compression is finished. It then drains the compressed words from an inbound buffer.

At each frame boundary an encode-enable input decides what comes next. If it is set, the next frame starts at once with no new command. If it is clear, the block emits a one-cycle termination pulse and goes back to idle.

Both buffers are plain synchronous first-in first-out memories inside the block. Frame length and readback length are parameters.

Top module: `frame_hs_ctrl`

## Requirements
- R1: After synchronous reset, `dma_req`, `end_op`, `out_valid` and `ovf` are 0 and `frames_done` is 0.
- R2: In idle, `pix_valid` is ignored: no pixel is stored and no DMA request is raised until `cap_cmd` is seen high on a clock edge.
- R3: During capture, pixels enter the outbound buffer in arrival order. A `dsp_rd` pulse on a non-empty buffer presents the oldest pixel on `dsp_rdata` from the next cycle on.
- R4: `dma_req` goes high one cycle after the outbound occupancy first reaches `OUT_DEPTH/2` from below. It stays high until a cycle with `dsp_ack` high clears it.
- R5: Within a frame, `dma_req` is raised again each time the occupancy falls below half and then reaches half once more.
- R6: Capture ends after `FRAME_PIX` cycles with `pix_valid` high. Pixels offered after that, while waiting for the interrupt, are not stored.
- R7: A pixel offered while the outbound buffer is full is dropped and sets `ovf`. `ovf` stays at 1 until reset.
- R8: Readback starts only on a rising edge of `dsp_irq`, seen after a two-flop synchronizer, while the block waits for it. An edge in any other phase is ignored. An input held high starts one readback.
- R9: Readback delivers exactly `FRAME_WORDS` words on `out_data`/`out_valid`, in the order written through `in_wr`. When the inbound buffer is empty, readback stalls with `out_valid` low.
- R10: After the last readback word, if `enc_valid` is 1 the block enters capture for the next frame without a new command.
- R11: After the last readback word, if `enc_valid` is 0, `end_op` is high for exactly one cycle and the block returns to idle.
- R12: `frames_done` increments once per completed readback and is cleared when `cap_cmd` is accepted in idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_cmd | input | 1 | Capture command, taken in idle |
| pix_valid | input | 1 | Preprocessed pixel strobe |
| pix_data | input | PIX_W | Preprocessed pixel |
| dma_req | output | 1 | DMA request toward the processor |
| dsp_ack | input | 1 | Processor acknowledge, clears `dma_req` |
| dsp_rd | input | 1 | Processor read strobe on the outbound buffer |
| dsp_rdata | output | PIX_W | Outbound buffer read data, one cycle after `dsp_rd` |
| dsp_irq | input | 1 | Asynchronous compression-done interrupt |
| in_wr | input | 1 | Processor write strobe into the inbound buffer |
| in_wdata | input | CW | Compressed word written by the processor |
| out_valid | output | 1 | Readback word valid |
| out_data | output | CW | Readback word |
| enc_valid | input | 1 | Encode enable, sampled at each frame boundary |
| end_op | output | 1 | One-cycle termination pulse |
| ovf | output | 1 | Sticky outbound overflow flag |
| frames_done | output | FCW | Frames completed since the last accepted command |

## Verification
The bench feeds pixels in groups of half the buffer depth, and it expects the request to fall at each acknowledge and rise again at the next crossing. A design that tested the level rather than the crossing would re-raise the request right after the acknowledge. One that tested the crossing only once per frame would stay silent on later groups.

Interrupts are sent during capture and held high for several cycles. A design without the phase check or the edge detector would start a readback on an empty buffer, and the capture that follows would then fail its read checks.

Readback is run once with the inbound buffer only partly loaded. A design that did not stall would emit invalid words, or the wrong count.

The bench also checks three smaller things:
- Pixels offered in idle and after the frame end are not stored.
- The overflow flag stays set through a full end-of-operation sequence.
- The termination pulse lasts exactly one cycle.

// File: rtl/frame_hs_pkg.sv
package frame_hs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CAPTURE,
    ST_WAIT_IRQ,
    ST_READBACK,
    ST_CHECK
  } fhs_state_t;
endpackage

// File: rtl/fhs_fifo.sv
module fhs_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [W-1:0]               wr_data,
  input  logic                       rd_en,
  output logic [W-1:0]               rd_data,
  output logic                       full,
  output logic                       empty,
  output logic [$clog2(DEPTH):0]     level
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] LVL_FULL = (AW+1)'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          wr_ok, rd_ok;

  assign full  = (level == LVL_FULL);
  assign empty = (level == '0);
  assign wr_ok = wr_en && !full;
  assign rd_ok = rd_en && !empty;

  // storage without reset so block RAM can be inferred
  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= wr_data;
    if (rd_ok) rd_data <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (wr_ok) wptr <= wptr + 1'b1;
      if (rd_ok) rptr <= rptr + 1'b1;
      case ({wr_ok, rd_ok})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/fhs_edge_sync.sv
module fhs_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic [STAGES:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= '0;
    else     sr <= {sr[STAGES-1:0], async_in};
  end

  // rising edge seen on the last synchronized stage
  assign rise = sr[STAGES-1] & ~sr[STAGES];
endmodule

// File: rtl/frame_hs_ctrl.sv
module frame_hs_ctrl
  import frame_hs_pkg::*;
#(
  parameter int PIX_W       = 8,
  parameter int CW          = 16,
  parameter int OUT_DEPTH   = 8,
  parameter int IN_DEPTH    = 8,
  parameter int FRAME_PIX   = 16,
  parameter int FRAME_WORDS = 4,
  parameter int FCW         = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_cmd,
  input  logic             pix_valid,
  input  logic [PIX_W-1:0] pix_data,
  output logic             dma_req,
  input  logic             dsp_ack,
  input  logic             dsp_rd,
  output logic [PIX_W-1:0] dsp_rdata,
  input  logic             dsp_irq,
  input  logic             in_wr,
  input  logic [CW-1:0]    in_wdata,
  output logic             out_valid,
  output logic [CW-1:0]    out_data,
  input  logic             enc_valid,
  output logic             end_op,
  output logic             ovf,
  output logic [FCW-1:0]   frames_done
);
  localparam int OAW = $clog2(OUT_DEPTH);
  localparam int IAW = $clog2(IN_DEPTH);
  localparam int PCW = $clog2(FRAME_PIX + 1);
  localparam int WCW = $clog2(FRAME_WORDS + 1);
  localparam logic [PCW-1:0] PIX_LAST  = PCW'(FRAME_PIX - 1);
  localparam logic [WCW-1:0] WORD_LAST = WCW'(FRAME_WORDS - 1);
  localparam logic [OAW:0]   OUT_HALF  = (OAW+1)'(OUT_DEPTH / 2);

  fhs_state_t     st;
  logic [PCW-1:0] pix_cnt;
  logic [WCW-1:0] word_cnt;
  logic           half_q;

  logic           out_full, out_empty, in_full, in_empty;
  logic [OAW:0]   out_level;
  logic [IAW:0]   in_level;
  logic           out_half, req_set;
  logic           in_capture, in_readback;
  logic           out_push, out_pop, in_push, in_pop, pix_drop;
  logic           irq_rise;

  assign in_capture  = (st == ST_CAPTURE);
  assign in_readback = (st == ST_READBACK);
  assign out_push    = in_capture && pix_valid && !out_full;
  assign pix_drop    = in_capture && pix_valid && out_full;
  assign out_pop     = dsp_rd && !out_empty;
  assign in_push     = in_wr && !in_full;
  assign in_pop      = in_readback && !in_empty;
  assign out_half    = (out_level >= OUT_HALF);
  assign req_set     = out_half && !half_q;

  fhs_fifo #(.W(PIX_W), .DEPTH(OUT_DEPTH)) u_out_fifo (
    .clk(clk), .rst(rst),
    .wr_en(out_push), .wr_data(pix_data),
    .rd_en(out_pop), .rd_data(dsp_rdata),
    .full(out_full), .empty(out_empty), .level(out_level)
  );

  fhs_fifo #(.W(CW), .DEPTH(IN_DEPTH)) u_in_fifo (
    .clk(clk), .rst(rst),
    .wr_en(in_push), .wr_data(in_wdata),
    .rd_en(in_pop), .rd_data(out_data),
    .full(in_full), .empty(in_empty), .level(in_level)
  );

  fhs_edge_sync #(.STAGES(SYNC_STAGES)) u_irq_sync (
    .clk(clk), .rst(rst), .async_in(dsp_irq), .rise(irq_rise)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      pix_cnt     <= '0;
      word_cnt    <= '0;
      frames_done <= '0;
      end_op      <= 1'b0;
      out_valid   <= 1'b0;
      ovf         <= 1'b0;
      dma_req     <= 1'b0;
      half_q      <= 1'b0;
    end else begin
      end_op    <= 1'b0;
      out_valid <= in_pop;
      half_q    <= out_half;
      if (req_set)      dma_req <= 1'b1;
      else if (dsp_ack) dma_req <= 1'b0;
      if (pix_drop) ovf <= 1'b1;

      case (st)
        ST_IDLE: begin
          if (cap_cmd) begin
            st          <= ST_CAPTURE;
            pix_cnt     <= '0;
            frames_done <= '0;
          end
        end
        ST_CAPTURE: begin
          if (pix_valid) begin
            if (pix_cnt == PIX_LAST) begin
              st      <= ST_WAIT_IRQ;
              pix_cnt <= '0;
            end else begin
              pix_cnt <= pix_cnt + 1'b1;
            end
          end
        end
        ST_WAIT_IRQ: begin
          if (irq_rise) begin
            st       <= ST_READBACK;
            word_cnt <= '0;
          end
        end
        ST_READBACK: begin
          if (in_pop) begin
            if (word_cnt == WORD_LAST) begin
              st          <= ST_CHECK;
              frames_done <= frames_done + 1'b1;
            end else begin
              word_cnt <= word_cnt + 1'b1;
            end
          end
        end
        ST_CHECK: begin
          if (enc_valid) begin
            st      <= ST_CAPTURE;
            pix_cnt <= '0;
          end else begin
            end_op <= 1'b1;
            st     <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fhs_checker.sv
module fhs_checker #(
  parameter int OUT_DEPTH = 8,
  parameter int IN_DEPTH  = 8
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         dma_req,
  input logic                         dsp_ack,
  input logic                         end_op,
  input logic                         ovf,
  input logic                         out_valid,
  input logic                         in_readback,
  input logic                         out_half,
  input logic [$clog2(OUT_DEPTH):0]   out_level,
  input logic [$clog2(IN_DEPTH):0]    in_level
);
  p_req_hold_r4: assert property (@(posedge clk) disable iff (rst)
    dma_req && !dsp_ack |=> dma_req);

  p_req_cause_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(dma_req) |-> $past(out_half));

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    out_level <= ($clog2(OUT_DEPTH)+1)'(OUT_DEPTH));

  p_in_level_r9: assert property (@(posedge clk) disable iff (rst)
    in_level <= ($clog2(IN_DEPTH)+1)'(IN_DEPTH));

  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf);

  p_word_in_readback_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_readback));

  p_end_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    end_op |=> !end_op);
endmodule

bind frame_hs_ctrl fhs_checker #(.OUT_DEPTH(OUT_DEPTH), .IN_DEPTH(IN_DEPTH)) u_chk (
  .clk(clk), .rst(rst), .dma_req(dma_req), .dsp_ack(dsp_ack),
  .end_op(end_op), .ovf(ovf), .out_valid(out_valid),
  .in_readback(in_readback), .out_half(out_half),
  .out_level(out_level), .in_level(in_level)
);

// File: tb/frame_hs_ctrl_tb.sv
module frame_hs_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PIX_W = 8;
  localparam int CW = 16;
  localparam int OUT_DEPTH = 8;
  localparam int FRAME_PIX = 16;
  localparam int FRAME_WORDS = 4;
  localparam int HALF = OUT_DEPTH / 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cap_cmd = 1'b0, pix_valid = 1'b0, dsp_ack = 1'b0, dsp_rd = 1'b0;
  logic dsp_irq = 1'b0, in_wr = 1'b0, enc_valid = 1'b0;
  logic [PIX_W-1:0] pix_data = '0;
  logic [CW-1:0] in_wdata = '0;
  logic dma_req, out_valid, end_op, ovf;
  logic [PIX_W-1:0] dsp_rdata;
  logic [CW-1:0] out_data;
  logic [7:0] frames_done;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int rx_cnt = 0;
  logic [CW-1:0] rx_buf [256];
  int end_cnt = 0;
  bit end_long = 1'b0;
  logic end_prev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_hs_ctrl #(.PIX_W(PIX_W), .CW(CW), .OUT_DEPTH(OUT_DEPTH), .IN_DEPTH(8),
                  .FRAME_PIX(FRAME_PIX), .FRAME_WORDS(FRAME_WORDS)) u_dut (
    .clk(clk), .rst(rst), .cap_cmd(cap_cmd), .pix_valid(pix_valid),
    .pix_data(pix_data), .dma_req(dma_req), .dsp_ack(dsp_ack), .dsp_rd(dsp_rd),
    .dsp_rdata(dsp_rdata), .dsp_irq(dsp_irq), .in_wr(in_wr), .in_wdata(in_wdata),
    .out_valid(out_valid), .out_data(out_data), .enc_valid(enc_valid),
    .end_op(end_op), .ovf(ovf), .frames_done(frames_done)
  );

  // observers sample away from the active edge
  always @(negedge clk) begin
    if (out_valid) begin
      rx_buf[rx_cnt & 255] <= out_data;
      rx_cnt <= rx_cnt + 1;
    end
    if (end_op) end_cnt <= end_cnt + 1;
    if (end_op && end_prev) end_long <= 1'b1;
    end_prev <= end_op;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_cmd();
    @(negedge clk) cap_cmd = 1'b1;
    @(negedge clk) cap_cmd = 1'b0;
  endtask

  task automatic push_pix(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pix_valid = 1'b1;
      pix_data = PIX_W'(base + i);
    end
    @(negedge clk) pix_valid = 1'b0;
  endtask

  task automatic do_ack();
    @(negedge clk) dsp_ack = 1'b1;
    @(negedge clk) dsp_ack = 1'b0;
  endtask

  task automatic read_pix(input int n, input int base, input string req);
    @(negedge clk) dsp_rd = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i == n - 1) dsp_rd = 1'b0;
      chk(dsp_rdata == PIX_W'(base + i), req, dsp_rdata, PIX_W'(base + i));
    end
  endtask

  task automatic write_words(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_wr = 1'b1;
      in_wdata = CW'(base + i);
    end
    @(negedge clk) in_wr = 1'b0;
  endtask

  task automatic pulse_irq(input int len);
    @(negedge clk) dsp_irq = 1'b1;
    cyc(len);
    dsp_irq = 1'b0;
  endtask

  // one frame from the capture phase to the boundary decision
  task automatic run_frame(input int pbase, input int wbase, input bit enc,
                           input bit stall, input int exp_frames);
    int rx0, e0;
    enc_valid = enc;
    for (int r = 0; r < FRAME_PIX / HALF; r++) begin
      push_pix(HALF, pbase + r * HALF);
      cyc(1);
      chk(dma_req == 1'b1, (r == 0) ? "R4 req on half" : "R5 req re-raised", dma_req, 1);
      do_ack();
      chk(dma_req == 1'b0, "R4 req cleared by ack", dma_req, 0);
      read_pix(HALF, pbase + r * HALF, "R3 pixel order");
      if (r == 0) begin
        // R8: interrupt during capture must be ignored
        rx0 = rx_cnt;
        pulse_irq(3);
        cyc(6);
        chk(rx_cnt == rx0, "R8 irq ignored in capture", rx_cnt - rx0, 0);
      end
    end
    // R6: frame is complete, extra pixels are not stored
    push_pix(HALF, 8'hE0);
    cyc(2);
    chk(dma_req == 1'b0, "R6 pixels after frame end", dma_req, 0);

    rx0 = rx_cnt;
    e0 = end_cnt;
    write_words(stall ? 2 : FRAME_WORDS, wbase);
    cyc(4);
    chk(rx_cnt == rx0, "R8 no readback before irq", rx_cnt - rx0, 0);
    pulse_irq(5);
    cyc(8);
    if (stall) begin
      chk(rx_cnt - rx0 == 2, "R9 stall on empty inbound", rx_cnt - rx0, 2);
      write_words(FRAME_WORDS - 2, wbase + 2);
    end
    cyc(10);
    chk(rx_cnt - rx0 == FRAME_WORDS, "R9 word count", rx_cnt - rx0, FRAME_WORDS);
    for (int i = 0; i < FRAME_WORDS; i++)
      chk(rx_buf[(rx0 + i) & 255] == CW'(wbase + i), "R9 word order",
          rx_buf[(rx0 + i) & 255], CW'(wbase + i));
    chk(frames_done == 8'(exp_frames), "R12 frame counter", frames_done, exp_frames);
    if (enc)
      chk(end_cnt == e0, "R10 no end when encode valid", end_cnt - e0, 0);
    else begin
      chk(end_cnt == e0 + 1, "R11 one end pulse", end_cnt - e0, 1);
      chk(!end_long, "R11 end pulse width", end_long, 0);
    end
  endtask

  task automatic t_reset();
    chk(dma_req == 0, "R1 dma_req", dma_req, 0);
    chk(end_op == 0 && out_valid == 0, "R1 end_op/out_valid", {end_op, out_valid}, 0);
    chk(ovf == 0, "R1 ovf", ovf, 0);
    chk(frames_done == 0, "R1 frames_done", frames_done, 0);
  endtask

  task automatic t_idle_ignore();
    push_pix(OUT_DEPTH, 8'h90);
    cyc(2);
    chk(dma_req == 0, "R2 no request in idle", dma_req, 0);
    chk(ovf == 0, "R2 no overflow in idle", ovf, 0);
  endtask

  task automatic t_two_frames();
    send_cmd();
    run_frame(8'h10, 16'h1A00, 1'b1, 1'b0, 1);   // R10 continue
    run_frame(8'h40, 16'h2B00, 1'b0, 1'b1, 2);   // R11 end, with stall
    // R11: back in idle, new pixels are not taken without a command
    push_pix(HALF, 8'h70);
    cyc(2);
    chk(dma_req == 0, "R11 idle after end", dma_req, 0);
  endtask

  task automatic t_overflow();
    int e0;
    send_cmd();
    chk(frames_done == 0, "R12 cleared by command", frames_done, 0);
    push_pix(FRAME_PIX, 8'hA0);
    cyc(1);
    chk(ovf == 1, "R7 overflow set", ovf, 1);
    do_ack();
    read_pix(OUT_DEPTH, 8'hA0, "R7 kept pixels");
    @(negedge clk) dsp_rd = 1'b1;
    @(negedge clk) dsp_rd = 1'b0;
    chk(dsp_rdata == 8'hA0 + OUT_DEPTH - 1, "R7 dropped pixel absent",
        dsp_rdata, 8'hA0 + OUT_DEPTH - 1);
    enc_valid = 1'b0;
    e0 = end_cnt;
    write_words(FRAME_WORDS, 16'h3C00);
    pulse_irq(2);
    cyc(16);
    chk(end_cnt == e0 + 1, "R11 end after overflow frame", end_cnt - e0, 1);
    chk(ovf == 1, "R7 overflow sticky", ovf, 1);
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    chk(ovf == 0, "R7 cleared by reset", ovf, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc(1);
    t_reset();
    t_idle_ignore();
    t_two_frames();
    t_overflow();
    cyc(2);
    summary();
  end
endmodule